// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level page table kept in memory. The virtual address has three parts: an upper index that selects an entry in the first-level table, a middle index that selects an entry in a second-level table, and a page offset. The first-level table sits at a base address supplied as an input. The walker reads the first-level entry. If that entry is present, its pointer field gives the base of a second-level table, and the walker reads the entry chosen by the middle index. The frame number in that entry, joined with the untouched offset, forms the physical address.

A request starts the walk, and a single-cycle done pulse ends it. The block makes its memory reads through a simple request/valid port that allows any latency, with only one read in flight at a time. When a not-present entry is found at either level, the walk stops at once and a fault code records the level that failed.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `done`, `mem_req` are 0, and `fault` is 00.
- R2: On `start` while idle, the first read goes to `root_base + vaddr[31:22]*4`. `mem_req` rises on the cycle after `start`.
- R3: When the first-level entry has bit 0 = 1, the second read goes to `{entry[31:12],12'b0} + vaddr[21:12]*4`.
- R4: On success, `paddr = {leaf[31:12], vaddr[11:0]}` and `fault = 00`. The offset bits pass through unchanged.
- R5: When the first-level entry has bit 0 = 0, the walk ends with `fault = 01` and no second read is made.
- R6: When the second-level entry has bit 0 = 0, the walk ends with `fault = 10`.
- R7: `done` is high for exactly one cycle per walk, on the cycle after the final `mem_rvalid`. `paddr` and `fault` hold their values until the next walk begins.
- R8: `start` has no effect while `busy` is high. The walk in progress keeps its captured address and table base.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_rvalid`, for any response latency. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of the first-level table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| paddr | output | 32 | Translated physical address |
| fault | output | 2 | 00 ok, 01 first-level miss, 10 second-level miss |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (page table entry) |

## Verification
A wrong captured address or table base shows up on `mem_addr` at the very next read request. This happens within one cycle of `start`, or one cycle after the first-level response. A wrong state transition shows up as a second-level read that is missing or extra, or as a wrong `fault` code on the `done` cycle. Because the bench varies the response latency, a walker that reads `mem_rdata` before `mem_rvalid`, or drops `mem_req` early, leaves a corrupted `paddr` or a stuck `busy`. Either one is seen by the end of that walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_L1    = 3'd1,
      S_L2    = 3'd2,
      S_DONE  = 3'd3
   } walk_state_e;

   localparam logic [1:0] FLT_NONE = 2'b00;
   localparam logic [1:0] FLT_L1   = 2'b01;
   localparam logic [1:0] FLT_L2   = 2'b10;
endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
   parameter int AW      = 32,
   parameter int IDX_W   = 10,
   parameter int PTE_BYTES = 4
) (
   input  logic [AW-1:0]    base,
   input  logic [IDX_W-1:0] index,
   output logic [AW-1:0]    entry_addr
);
   localparam int SHIFT = $clog2(PTE_BYTES);

   initial begin
      if (PTE_BYTES != (1 << SHIFT))
         $error("PTE_BYTES must be a power of two");
   end

   always_comb begin
      entry_addr = base + (AW'(index) << SHIFT);
   end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
   parameter int DW     = 32,
   parameter int PAGE_W = 12
) (
   input  logic [DW-1:0] pte,
   output logic          present,
   output logic [DW-1:0] frame_base
);
   always_comb begin
      present    = pte[0];
      frame_base = {pte[DW-1:PAGE_W], {PAGE_W{1'b0}}};
   end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int AW     = 32,
   parameter int PAGE_W = 12,
   parameter int IDX_W  = 10,
   parameter int PTE_BYTES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [31:0]   vaddr,
   input  logic [31:0]   root_base,
   output logic          busy,
   output logic          done,
   output logic [31:0]   paddr,
   output logic [1:0]    fault,
   output logic          mem_req,
   output logic [31:0]   mem_addr,
   input  logic          mem_rvalid,
   input  logic [31:0]   mem_rdata
);
   import ptw_pkg::*;

   localparam int L1_LO = PAGE_W + IDX_W;
   localparam int L2_LO = PAGE_W;

   initial begin
      if (AW != 32) $error("AW must be 32");
      if (PAGE_W + 2*IDX_W != AW) $error("field widths must cover the address");
   end

   walk_state_e state_q;
   logic [AW-1:0] va_q, root_q, l2_base_q, addr_l1, addr_l2, frame;
   logic          pres;

   ptw_addr_calc #(.AW(AW), .IDX_W(IDX_W), .PTE_BYTES(PTE_BYTES)) u_calc_l1 (
      .base(root_q), .index(va_q[L1_LO +: IDX_W]), .entry_addr(addr_l1));
   ptw_addr_calc #(.AW(AW), .IDX_W(IDX_W), .PTE_BYTES(PTE_BYTES)) u_calc_l2 (
      .base(l2_base_q), .index(va_q[L2_LO +: IDX_W]), .entry_addr(addr_l2));
   ptw_entry_decode #(.DW(AW), .PAGE_W(PAGE_W)) u_dec (
      .pte(mem_rdata), .present(pres), .frame_base(frame));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         va_q      <= '0;
         root_q    <= '0;
         l2_base_q <= '0;
         paddr     <= '0;
         fault     <= FLT_NONE;
      end else begin
         case (state_q)
            S_IDLE: if (start) begin
               va_q    <= vaddr;
               root_q  <= root_base;
               state_q <= S_L1;
            end
            S_L1: if (mem_rvalid) begin
               if (pres) begin
                  l2_base_q <= frame;
                  state_q   <= S_L2;
               end else begin
                  fault   <= FLT_L1;
                  paddr   <= '0;
                  state_q <= S_DONE;
               end
            end
            S_L2: if (mem_rvalid) begin
               if (pres) begin
                  fault <= FLT_NONE;
                  paddr <= {frame[AW-1:PAGE_W], va_q[PAGE_W-1:0]};
               end else begin
                  fault <= FLT_L2;
                  paddr <= '0;
               end
               state_q <= S_DONE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      busy     = (state_q != S_IDLE);
      done     = (state_q == S_DONE);
      mem_req  = (state_q == S_L1) || (state_q == S_L2);
      mem_addr = (state_q == S_L2) ? addr_l2 : addr_l1;
   end

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R5
   l1_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault == FLT_L1) |-> paddr == '0);
   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(va_q) && $stable(root_q));
   // R2
   req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> mem_req);
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(paddr) && $stable(fault));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
   logic clk = 0, rst_n = 0, start = 0, mem_rvalid = 0;
   logic [31:0] vaddr = 0, root_base = 0, mem_rdata = 0;
   logic busy, done, mem_req;
   logic [31:0] paddr, mem_addr;
   logic [1:0] fault;
   int n_tests = 0, n_fail = 0, reads = 0;

   always #10 clk = ~clk;

   pt_walker dut (.clk, .rst_n, .start, .vaddr, .root_base, .busy, .done,
      .paddr, .fault, .mem_req, .mem_addr, .mem_rvalid, .mem_rdata);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // serve one read: wait for req, check addr, respond after lat cycles
   task automatic serve(input string req, input logic [31:0] exp_addr,
                        input logic [31:0] data, input int lat);
      while (!mem_req) @(negedge clk);
      chk(req, mem_addr, exp_addr);
      reads++;
      for (int i = 0; i < lat; i++) begin
         @(negedge clk);
         chk("R9", {mem_req, mem_addr[30:0]}, {1'b1, exp_addr[30:0]});
      end
      mem_rvalid = 1; mem_rdata = data;
      @(negedge clk);
      mem_rvalid = 0; mem_rdata = 32'hxxxx_xxxx;
   endtask

   task automatic go(input logic [31:0] va, input logic [31:0] rb);
      vaddr = va; root_base = rb; start = 1;
      @(negedge clk);
      start = 0;
      chk("R2", {31'b0, mem_req}, 1);
   endtask

   task automatic finish_chk(input logic [31:0] exp_pa, input logic [1:0] exp_f);
      chk("R7", {31'b0, done}, 1);
      chk("R4", paddr, exp_pa);
      chk("R5/R6", {30'b0, fault}, {30'b0, exp_f});
      @(negedge clk);
      chk("R7", {30'b0, done, busy}, 0);
      chk("R7", paddr, exp_pa);
   endtask

   task automatic t_success(input logic [31:0] va, input int lat);
      logic [31:0] rb = 32'h0010_0000;
      go(va, rb);
      serve("R2", rb + {20'b0, va[31:22], 2'b0}, 32'h0020_3001, lat);
      serve("R3", 32'h0020_3000 + {20'b0, va[21:12], 2'b0}, 32'hABCDE_001, lat);
      finish_chk({20'hABCDE, va[11:0]}, 2'b00);
   endtask

   task automatic t_l1_fault();
      int r0;
      go(32'hFFC0_0123, 32'h0000_4000);
      r0 = reads;
      serve("R2", 32'h0000_4000 + 32'h3FF*4, 32'h0020_3000, 0);
      chk("R5", {31'b0, mem_req}, 0);
      chk("R5", reads - r0, 1);
      finish_chk(32'h0, 2'b01);
   endtask

   task automatic t_l2_fault();
      go(32'h0000_1FFF, 32'h0000_8000);
      serve("R2", 32'h0000_8000, 32'h0030_0001, 1);
      serve("R3", 32'h0030_0004, 32'h1234_5000, 2);
      finish_chk(32'h0, 2'b10);
   endtask

   task automatic t_busy_start();
      go(32'h0040_2555, 32'h0000_0000);
      vaddr = 32'hFFFF_FFFF; root_base = 32'h8000_0000; start = 1;
      serve("R8", 32'h0000_0004, 32'h0050_0001, 2);
      serve("R8", 32'h0050_0008, 32'h7777_7001, 1);
      start = 0;
      finish_chk(32'h7777_7555, 2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", {29'b0, busy, done, mem_req}, 0);
      chk("R1", {30'b0, fault}, 0);
      rst_n = 1;
      @(negedge clk);
      t_success(32'h1234_5678, 0);
      t_success(32'h0000_0ABC, 3);
      t_success(32'hFFFF_FFFF, 5);
      t_l1_fault();
      t_l2_fault();
      t_busy_start();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule